// File: doc/BRIEF.md
# Parallel Register Move Unit

This block holds a small register file and runs one of three multi-register move commands on it. A swizzle copies two arbitrary sources to two arbitrary destinations. A gather copies four arbitrary sources into four consecutive destinations. A scatter copies four consecutive sources out to four arbitrary destinations. Every command reads all of its operands into a snapshot before it writes any result. The outcome is therefore the same as if all moves happened at once, so two registers can be swapped in place and source and destination ranges may overlap.

Each command carries a source type code and a destination type code. These codes decide whether each side is a half-width operand (the low 16 bits of an entry) or a full 32-bit operand. The block widens or narrows values as it writes them. Commands enter through a valid/ready handshake. While a command runs, `busy` is high. A one-cycle `done` marks its end. A reserved opcode or an index outside the file is rejected with its own one-cycle flag. A debug port reads the file at any time and writes it while the block is idle.

Top module: `pmove_unit`

## Requirements
- R1: `cmd_op` selects the operation: 2'b00 swizzle, 2'b01 gather, 2'b10 scatter. The value 2'b11 is rejected. `err_illegal` goes high for exactly the one cycle after the handshake, `busy` stays low and no register is written.
- R2: Swizzle writes source slot 0 to destination slot 0 and source slot 1 to destination slot 1. Naming the same two registers in crossed order exchanges their contents.
- R3: Gather writes source slot k to register `cmd_dst` slot 0 plus k, for k = 0..3.
- R4: Scatter writes register `cmd_src` slot 0 plus k to destination slot k, for k = 0..3.
- R5: All source values are captured before the first write. The final file equals a parallel move even when sources and destinations overlap.
- R6: Type codes 0, 2, 4, 6 and 7 are half width; codes 1, 3 and 5 are full width. A half source reads bits 15:0 of its entry. A half destination replaces bits 15:0 and keeps bits 31:16.
- R7: When a half source goes to a full destination, the value is sign-extended from bit 15 for source codes 4 and 7 and zero-extended for the other half codes. A full source going to a half destination contributes its bits 15:0.
- R8: When two destination slots of one command name the same register, that register ends with the value of the higher slot.
- R9: If any effective index that the command uses is 64 or more (base plus offset included), `err_range` goes high for exactly the one cycle after the handshake, `busy` stays low and nothing is written.
- R10: `cmd_ready` is high exactly when the block is idle. After an accepted legal command, `busy` stays high for 2N cycles, where N is 2 for swizzle and 4 otherwise. `done` is then high for one cycle, in the first cycle with `busy` low.
- R11: `dbg_rdata` always shows the entry at `dbg_addr`. A `dbg_we` write of the full word takes effect only while `busy` is low and is ignored while `busy` is high.
- R12: After reset every entry reads zero, `cmd_ready` is high, and `busy`, `done`, `err_illegal` and `err_range` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Block idle, command taken on this edge if valid |
| cmd_op | input | 2 | Operation select |
| cmd_src_type | input | 3 | Source type code |
| cmd_dst_type | input | 3 | Destination type code |
| cmd_src | input | SLOTS*IDX_W (28) | Source indices, slot k at bits k*IDX_W upward |
| cmd_dst | input | SLOTS*IDX_W (28) | Destination indices, same packing |
| busy | output | 1 | Read or write phase in progress |
| done | output | 1 | One-cycle pulse after the last write |
| err_illegal | output | 1 | One-cycle pulse for a reserved opcode |
| err_range | output | 1 | One-cycle pulse for an index past the file |
| dbg_we | input | 1 | Debug full-word write enable |
| dbg_addr | input | 6 | Debug address |
| dbg_wdata | input | 32 | Debug write data |
| dbg_rdata | output | 32 | Debug read data |

## Verification
The bench aims at overlap hazards: crossed swizzle swaps, gathers whose destination range covers their own sources, and scatters that permute their own source window. A design that wrote each result as soon as it was read would spread one value over both registers of a swap instead of exchanging them. Swizzle swaps are swept over all 64 type pairs to check half/full selection and extension. Wrong extension would show up as bad upper bits in negative 16-bit values, and a half write that cleared bits 31:16 would also be caught. Duplicate destinations, base-plus-offset indices that run past the end, the reserved opcode and debug writes issued while busy are each checked against the whole file, so that a stray write anywhere is detected.

// File: rtl/pmove_pkg.sv
// Shared types and type-code helpers for the parallel register move unit.
// Assumes 3-bit type codes; half-width codes are 0,2,4,6,7.
package pmove_pkg;

    localparam int TYPE_W = 3;

    typedef enum logic [1:0] {
        OP_SWZ = 2'b00,
        OP_GAT = 2'b01,
        OP_SCT = 2'b10,
        OP_RSV = 2'b11
    } pm_op_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'b00,
        ST_READ  = 2'b01,
        ST_WRITE = 2'b10
    } pm_state_e;

    // True when the type code names a half-width operand.
    function automatic logic type_is_half(input logic [TYPE_W-1:0] t);
        case (t)
            3'd0, 3'd2, 3'd4, 3'd6, 3'd7: type_is_half = 1'b1;
            default:                      type_is_half = 1'b0;
        endcase
    endfunction

    // True when a half source of this code must be sign-extended.
    function automatic logic type_sign_ext(input logic [TYPE_W-1:0] t);
        type_sign_ext = (t == 3'd4) || (t == 3'd7);
    endfunction

endpackage

// File: rtl/pmove_regfile.sv
// Register file: one write port with a low-half-only mode, one operand
// read port and one debug read port, both combinational.
// Assumes the caller never needs two writes in one cycle.
module pmove_regfile #(
    parameter int DATA_W    = 32,
    parameter int REG_COUNT = 64
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         wr_en,
    input  logic                         wr_low_only,
    input  logic [$clog2(REG_COUNT)-1:0] wr_addr,
    input  logic [DATA_W-1:0]            wr_data,
    input  logic [$clog2(REG_COUNT)-1:0] rd_addr,
    output logic [DATA_W-1:0]            rd_data,
    input  logic [$clog2(REG_COUNT)-1:0] dbg_addr,
    output logic [DATA_W-1:0]            dbg_data
);
    localparam int HALF_W = DATA_W / 2;

    logic [DATA_W-1:0] mem_q [REG_COUNT];

    // Storage update: clear on reset, full or low-half write otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < REG_COUNT; i++) begin
                mem_q[i] <= '0;
            end
        end else if (wr_en) begin
            if (wr_low_only) begin
                mem_q[wr_addr][HALF_W-1:0] <= wr_data[HALF_W-1:0];
            end else begin
                mem_q[wr_addr] <= wr_data;
            end
        end
    end

    // Read ports.
    always_comb begin
        rd_data  = mem_q[rd_addr];
        dbg_data = mem_q[dbg_addr];
    end
endmodule

// File: rtl/pmove_ctrl.sv
// Command sequencer: accepts commands, checks opcode and index range,
// resolves effective addresses for every slot, then steps through a read
// phase and a write phase at one operand per cycle.
// Assumes SLOTS >= 2 and REG_COUNT <= 2**IDX_W.
module pmove_ctrl
    import pmove_pkg::*;
#(
    parameter int REG_COUNT = 64,
    parameter int IDX_W     = 7,
    parameter int SLOTS     = 4
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         cmd_valid,
    output logic                         cmd_ready,
    input  logic [1:0]                   cmd_op,
    input  logic [SLOTS*IDX_W-1:0]       cmd_src,
    input  logic [SLOTS*IDX_W-1:0]       cmd_dst,
    output logic                         busy,
    output logic                         done,
    output logic                         err_illegal,
    output logic                         err_range,
    output logic                         rd_fire,
    output logic [$clog2(REG_COUNT)-1:0] rd_addr,
    output logic [$clog2(SLOTS)-1:0]     rd_slot,
    output logic                         wr_fire,
    output logic [$clog2(REG_COUNT)-1:0] wr_addr,
    output logic [$clog2(SLOTS)-1:0]     wr_slot
);
    localparam int ADDR_W = $clog2(REG_COUNT);
    localparam int STEP_W = $clog2(SLOTS);
    localparam int EFF_W  = IDX_W + 1;

    pm_state_e         state_q;
    logic [STEP_W-1:0] step_q;
    logic [STEP_W-1:0] last_q;
    logic [ADDR_W-1:0] src_eff_q [SLOTS];
    logic [ADDR_W-1:0] dst_eff_q [SLOTS];
    logic              done_q;
    logic              ill_q;
    logic              rng_q;

    logic [EFF_W-1:0]  src_eff [SLOTS];
    logic [EFF_W-1:0]  dst_eff [SLOTS];
    logic [SLOTS-1:0]  slot_bad;
    logic [STEP_W-1:0] n_last;

    // Number of moves minus one for the offered command.
    always_comb begin
        n_last = (cmd_op == OP_SWZ) ? STEP_W'(1) : STEP_W'(SLOTS - 1);
    end

    // Effective per-slot addresses and range check for the offered command.
    always_comb begin
        for (int k = 0; k < SLOTS; k++) begin
            if (cmd_op == OP_SCT) begin
                src_eff[k] = {1'b0, cmd_src[0 +: IDX_W]} + EFF_W'(k);
            end else begin
                src_eff[k] = {1'b0, cmd_src[k*IDX_W +: IDX_W]};
            end
            if (cmd_op == OP_GAT) begin
                dst_eff[k] = {1'b0, cmd_dst[0 +: IDX_W]} + EFF_W'(k);
            end else begin
                dst_eff[k] = {1'b0, cmd_dst[k*IDX_W +: IDX_W]};
            end
            slot_bad[k] = (STEP_W'(k) <= n_last) &&
                          ((src_eff[k] >= EFF_W'(REG_COUNT)) ||
                           (dst_eff[k] >= EFF_W'(REG_COUNT)));
        end
    end

    // Phase sequencing, command latching and one-cycle status pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            step_q  <= '0;
            last_q  <= '0;
            done_q  <= 1'b0;
            ill_q   <= 1'b0;
            rng_q   <= 1'b0;
            for (int k = 0; k < SLOTS; k++) begin
                src_eff_q[k] <= '0;
                dst_eff_q[k] <= '0;
            end
        end else begin
            done_q <= 1'b0;
            ill_q  <= 1'b0;
            rng_q  <= 1'b0;
            case (state_q)
                ST_IDLE: begin
                    if (cmd_valid) begin
                        if (cmd_op == OP_RSV) begin
                            ill_q <= 1'b1;
                        end else if (|slot_bad) begin
                            rng_q <= 1'b1;
                        end else begin
                            state_q <= ST_READ;
                            step_q  <= '0;
                            last_q  <= n_last;
                            for (int k = 0; k < SLOTS; k++) begin
                                src_eff_q[k] <= src_eff[k][ADDR_W-1:0];
                                dst_eff_q[k] <= dst_eff[k][ADDR_W-1:0];
                            end
                        end
                    end
                end
                ST_READ: begin
                    if (step_q == last_q) begin
                        state_q <= ST_WRITE;
                        step_q  <= '0;
                    end else begin
                        step_q <= step_q + 1'b1;
                    end
                end
                ST_WRITE: begin
                    if (step_q == last_q) begin
                        state_q <= ST_IDLE;
                        done_q  <= 1'b1;
                    end else begin
                        step_q <= step_q + 1'b1;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // Outputs derived from the phase and step.
    always_comb begin
        cmd_ready   = (state_q == ST_IDLE);
        busy        = (state_q != ST_IDLE);
        done        = done_q;
        err_illegal = ill_q;
        err_range   = rng_q;
        rd_fire     = (state_q == ST_READ);
        wr_fire     = (state_q == ST_WRITE);
        rd_slot     = step_q;
        wr_slot     = step_q;
        rd_addr     = src_eff_q[step_q];
        wr_addr     = dst_eff_q[step_q];
    end
endmodule

// File: rtl/pmove_snap.sv
// Operand snapshot: holds every source value of a command, widened to the
// full word at capture, and reports whether the destination is half width.
// Assumes load_types is pulsed when a command is taken.
module pmove_snap
    import pmove_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int SLOTS  = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     load_types,
    input  logic [TYPE_W-1:0]        in_src_type,
    input  logic [TYPE_W-1:0]        in_dst_type,
    input  logic                     cap_en,
    input  logic [$clog2(SLOTS)-1:0] cap_slot,
    input  logic [DATA_W-1:0]        cap_data,
    input  logic [$clog2(SLOTS)-1:0] out_slot,
    output logic [DATA_W-1:0]        out_data,
    output logic                     out_half
);
    localparam int HALF_W = DATA_W / 2;

    logic [DATA_W-1:0] slot_q [SLOTS];
    logic [TYPE_W-1:0] src_t_q;
    logic [TYPE_W-1:0] dst_t_q;
    logic [DATA_W-1:0] widened;

    // Widen a captured source according to its type code.
    always_comb begin
        if (!type_is_half(src_t_q)) begin
            widened = cap_data;
        end else if (type_sign_ext(src_t_q)) begin
            widened = {{(DATA_W-HALF_W){cap_data[HALF_W-1]}}, cap_data[HALF_W-1:0]};
        end else begin
            widened = {{(DATA_W-HALF_W){1'b0}}, cap_data[HALF_W-1:0]};
        end
    end

    // Type latching and snapshot capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            src_t_q <= '0;
            dst_t_q <= '0;
            for (int k = 0; k < SLOTS; k++) begin
                slot_q[k] <= '0;
            end
        end else begin
            if (load_types) begin
                src_t_q <= in_src_type;
                dst_t_q <= in_dst_type;
            end
            if (cap_en) begin
                slot_q[cap_slot] <= widened;
            end
        end
    end

    // Write-back value and width selection.
    always_comb begin
        out_data = slot_q[out_slot];
        out_half = type_is_half(dst_t_q);
    end
endmodule

// File: rtl/pmove_unit.sv
// Top of the parallel register move unit: sequencer, snapshot and register
// file, plus the debug port that shares the write port while idle.
// Assumes debug writes and command writes never coincide (idle gating).
module pmove_unit
    import pmove_pkg::*;
#(
    parameter int DATA_W    = 32,
    parameter int REG_COUNT = 64,
    parameter int IDX_W     = 7,
    parameter int SLOTS     = 4
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         cmd_valid,
    output logic                         cmd_ready,
    input  logic [1:0]                   cmd_op,
    input  logic [2:0]                   cmd_src_type,
    input  logic [2:0]                   cmd_dst_type,
    input  logic [SLOTS*IDX_W-1:0]       cmd_src,
    input  logic [SLOTS*IDX_W-1:0]       cmd_dst,
    output logic                         busy,
    output logic                         done,
    output logic                         err_illegal,
    output logic                         err_range,
    input  logic                         dbg_we,
    input  logic [$clog2(REG_COUNT)-1:0] dbg_addr,
    input  logic [DATA_W-1:0]            dbg_wdata,
    output logic [DATA_W-1:0]            dbg_rdata
);
    localparam int ADDR_W = $clog2(REG_COUNT);
    localparam int STEP_W = $clog2(SLOTS);

    logic              rd_fire;
    logic              wr_fire;
    logic [ADDR_W-1:0] rd_addr;
    logic [ADDR_W-1:0] seq_wr_addr;
    logic [STEP_W-1:0] rd_slot;
    logic [STEP_W-1:0] wr_slot;
    logic [DATA_W-1:0] rd_data;
    logic [DATA_W-1:0] snap_data;
    logic              snap_half;
    logic              rf_we;
    logic              rf_low_only;
    logic [ADDR_W-1:0] rf_addr;
    logic [DATA_W-1:0] rf_wdata;

    pmove_ctrl #(
        .REG_COUNT (REG_COUNT),
        .IDX_W     (IDX_W),
        .SLOTS     (SLOTS)
    ) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .cmd_valid   (cmd_valid),
        .cmd_ready   (cmd_ready),
        .cmd_op      (cmd_op),
        .cmd_src     (cmd_src),
        .cmd_dst     (cmd_dst),
        .busy        (busy),
        .done        (done),
        .err_illegal (err_illegal),
        .err_range   (err_range),
        .rd_fire     (rd_fire),
        .rd_addr     (rd_addr),
        .rd_slot     (rd_slot),
        .wr_fire     (wr_fire),
        .wr_addr     (seq_wr_addr),
        .wr_slot     (wr_slot)
    );

    pmove_snap #(
        .DATA_W (DATA_W),
        .SLOTS  (SLOTS)
    ) u_snap (
        .clk         (clk),
        .rst_n       (rst_n),
        .load_types  (cmd_valid && cmd_ready),
        .in_src_type (cmd_src_type),
        .in_dst_type (cmd_dst_type),
        .cap_en      (rd_fire),
        .cap_slot    (rd_slot),
        .cap_data    (rd_data),
        .out_slot    (wr_slot),
        .out_data    (snap_data),
        .out_half    (snap_half)
    );

    // Write-port sharing: sequencer writes while busy, debug writes when idle.
    always_comb begin
        rf_we       = wr_fire || (dbg_we && !busy);
        rf_low_only = wr_fire && snap_half;
        rf_addr     = wr_fire ? seq_wr_addr : dbg_addr;
        rf_wdata    = wr_fire ? snap_data : dbg_wdata;
    end

    pmove_regfile #(
        .DATA_W    (DATA_W),
        .REG_COUNT (REG_COUNT)
    ) u_rf (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en       (rf_we),
        .wr_low_only (rf_low_only),
        .wr_addr     (rf_addr),
        .wr_data     (rf_wdata),
        .rd_addr     (rd_addr),
        .rd_data     (rd_data),
        .dbg_addr    (dbg_addr),
        .dbg_data    (dbg_rdata)
    );
endmodule

// File: rtl/pmove_unit_chk.sv
// Protocol checker for the parallel register move unit, bound to the top.
module pmove_unit_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       cmd_valid,
    input logic       cmd_ready,
    input logic [1:0] cmd_op,
    input logic       busy,
    input logic       done,
    input logic       err_illegal,
    input logic       err_range
);
    // R1
    illegal_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_ready && cmd_op == 2'b11) |=> (err_illegal && !busy));

    // R10
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R10
    done_ends_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && $past(busy)));

    // R9
    range_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err_range |-> (!busy && cmd_ready));

    // R1
    status_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({done, err_illegal, err_range}));
endmodule

bind pmove_unit pmove_unit_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cmd_valid   (cmd_valid),
    .cmd_ready   (cmd_ready),
    .cmd_op      (cmd_op),
    .busy        (busy),
    .done        (done),
    .err_illegal (err_illegal),
    .err_range   (err_range)
);

// File: tb/pmove_unit_test.sv
module pmove_unit_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic        cmd_ready;
    logic [1:0]  cmd_op = '0;
    logic [2:0]  cmd_src_type = '0;
    logic [2:0]  cmd_dst_type = '0;
    logic [27:0] cmd_src = '0;
    logic [27:0] cmd_dst = '0;
    logic        busy, done, err_illegal, err_range;
    logic        dbg_we = 1'b0;
    logic [5:0]  dbg_addr = '0;
    logic [31:0] dbg_wdata = '0;
    logic [31:0] dbg_rdata;

    int vecs = 0;
    int fails = 0;
    logic [31:0] model [64];

    always #10 clk = ~clk;

    pmove_unit uut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
        .cmd_op(cmd_op), .cmd_src_type(cmd_src_type), .cmd_dst_type(cmd_dst_type),
        .cmd_src(cmd_src), .cmd_dst(cmd_dst), .busy(busy), .done(done),
        .err_illegal(err_illegal), .err_range(err_range), .dbg_we(dbg_we),
        .dbg_addr(dbg_addr), .dbg_wdata(dbg_wdata), .dbg_rdata(dbg_rdata)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        vecs++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic bit is_half(input int t);
        return (t == 0) || (t == 2) || (t == 4) || (t == 6) || (t == 7);
    endfunction

    // Expected write value from R6/R7.
    function automatic logic [31:0] conv(input logic [31:0] sv, input logic [31:0] old,
                                         input int st, input int dt);
        logic [31:0] v;
        if (!is_half(st)) v = sv;
        else if (st == 4 || st == 7) v = {{16{sv[15]}}, sv[15:0]};
        else v = {16'h0, sv[15:0]};
        if (is_half(dt)) return {old[31:16], v[15:0]};
        return v;
    endfunction

    task automatic compare_file(input string req);
        for (int i = 0; i < 64; i++) begin
            dbg_addr = 6'(i);
            #1;
            chk($sformatf("%s reg %0d", req, i), dbg_rdata, model[i]);
        end
    endtask

    task automatic load_pattern(input logic [31:0] seed);
        for (int i = 0; i < 64; i++) begin
            @(negedge clk);
            dbg_we = 1'b1;
            dbg_addr = 6'(i);
            dbg_wdata = (32'(i) * 32'h9E3779B1) ^ seed;
            model[i] = dbg_wdata;
        end
        @(negedge clk);
        dbg_we = 1'b0;
    endtask

    task automatic run_cmd(input string req, input int op, input int st, input int dt,
                           input int s [4], input int d [4], input bit poke);
        int n;
        int cyc;
        bit rng;
        logic [31:0] snap [4];
        n = (op == 0) ? 2 : 4;
        rng = 1'b0;
        for (int k = 0; k < n; k++) begin
            int sa, da;
            sa = (op == 2) ? s[0] + k : s[k];
            da = (op == 1) ? d[0] + k : d[k];
            if (sa > 63 || da > 63) rng = 1'b1;
        end
        @(negedge clk);
        cmd_valid = 1'b1;
        cmd_op = 2'(op);
        cmd_src_type = 3'(st);
        cmd_dst_type = 3'(dt);
        for (int k = 0; k < 4; k++) begin
            cmd_src[k*7 +: 7] = 7'(s[k]);
            cmd_dst[k*7 +: 7] = 7'(d[k]);
        end
        chk({req, " R10 ready idle"}, 32'(cmd_ready), 32'd1);
        @(negedge clk);
        cmd_valid = 1'b0;
        if (op == 3) begin
            chk({req, " R1 err_illegal"}, 32'(err_illegal), 32'd1);
            chk({req, " R1 busy"}, 32'(busy), 32'd0);
        end else if (rng) begin
            chk({req, " R9 err_range"}, 32'(err_range), 32'd1);
            chk({req, " R9 busy"}, 32'(busy), 32'd0);
        end else begin
            for (int k = 0; k < n; k++) begin
                snap[k] = model[(op == 2) ? s[0] + k : s[k]];
            end
            for (int k = 0; k < n; k++) begin
                int da;
                da = (op == 1) ? d[0] + k : d[k];
                model[da] = conv(snap[k], model[da], st, dt);
            end
            if (poke) begin
                dbg_we = 1'b1;
                dbg_addr = 6'd63;
                dbg_wdata = 32'hDEAD_BEEF;
            end
            cyc = 0;
            while (!done && cyc < 100) begin
                if (busy) cyc++;
                @(negedge clk);
                dbg_we = 1'b0;
            end
            chk({req, " R10 done"}, 32'(done), 32'd1);
            chk({req, " R10 busy cycles"}, 32'(cyc), 32'(2 * n));
            chk({req, " R10 busy low at done"}, 32'(busy), 32'd0);
        end
        compare_file(req);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
        $finish;
    end

    initial begin
        int s [4];
        int d [4];
        for (int i = 0; i < 64; i++) model[i] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R12 reset state
        chk("R12 cmd_ready", 32'(cmd_ready), 32'd1);
        chk("R12 busy", 32'(busy), 32'd0);
        chk("R12 done", 32'(done), 32'd0);
        chk("R12 err_illegal", 32'(err_illegal), 32'd0);
        chk("R12 err_range", 32'(err_range), 32'd0);
        compare_file("R12 zero file");

        // R11 debug write and read-back
        load_pattern(32'h0000_8000);
        compare_file("R11 debug load");

        // R2 R5 R6 R7: crossed swizzle swap over every type pair
        for (int st = 0; st < 8; st++) begin
            for (int dt = 0; dt < 8; dt++) begin
                int a;
                a = (st * 8 + dt) % 64;
                s = '{a, (a + 17) % 64, 0, 0};
                d = '{(a + 17) % 64, a, 0, 0};
                run_cmd($sformatf("R2 R5 R6 R7 swap st%0d dt%0d", st, dt), 0, st, dt, s, d, 1'b0);
            end
        end

        // R3 R5: gather with destination window covering its sources
        load_pattern(32'h5A5A_0F0F);
        for (int b = 0; b <= 57; b += 3) begin
            s = '{b + 2, (b + 5) % 64, b, b + 1};
            d = '{b, 0, 0, 0};
            run_cmd($sformatf("R3 R5 gather base %0d", b), 1, (b / 3) % 8, 5 - (b % 2) * 4, s, d, 1'b0);
        end

        // R4 R5: scatter permuting its own source window
        for (int b = 0; b <= 57; b += 3) begin
            s = '{b, 0, 0, 0};
            d = '{b + 1, b, b + 3, b + 2};
            run_cmd($sformatf("R4 R5 scatter base %0d", b), 2, 1 + (b % 2) * 6, (b / 3) % 8, s, d, 1'b0);
        end

        // R8: duplicate destinations, highest slot wins
        s = '{10, 11, 0, 0};
        d = '{5, 5, 0, 0};
        run_cmd("R8 swizzle dup", 0, 1, 1, s, d, 1'b0);
        s = '{20, 0, 0, 0};
        d = '{7, 9, 7, 7};
        run_cmd("R8 scatter dup", 2, 3, 3, s, d, 1'b0);

        // R9: indices past the end, including base plus offset
        s = '{1, 2, 3, 4};
        d = '{61, 0, 0, 0};
        run_cmd("R9 gather base 61", 1, 1, 1, s, d, 1'b0);
        s = '{62, 0, 0, 0};
        d = '{1, 2, 3, 4};
        run_cmd("R9 scatter base 62", 2, 1, 1, s, d, 1'b0);
        s = '{64, 3, 0, 0};
        d = '{1, 2, 0, 0};
        run_cmd("R9 swizzle src 64", 0, 1, 1, s, d, 1'b0);
        s = '{3, 4, 0, 0};
        d = '{1, 127, 0, 0};
        run_cmd("R9 swizzle dst 127", 0, 1, 1, s, d, 1'b0);

        // R1: reserved opcode
        s = '{1, 2, 3, 4};
        d = '{5, 6, 7, 8};
        run_cmd("R1 reserved op", 3, 1, 1, s, d, 1'b0);

        // R11: debug write while busy is ignored
        s = '{30, 31, 0, 0};
        d = '{31, 30, 0, 0};
        run_cmd("R11 poke while busy", 0, 5, 5, s, d, 1'b1);

        // R1 R2: a normal command still works after rejections
        s = '{40, 41, 0, 0};
        d = '{41, 40, 0, 0};
        run_cmd("R1 R2 after reject", 0, 4, 5, s, d, 1'b0);

        $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
        $finish;
    end
endmodule